// File: doc/BRIEF.md
# PLL Divider Search Engine

This block picks divider settings for a PLL whose output rate is `ref * F / (2 * R * OD)`, with every division truncating. Software or a boot sequencer presents a reference rate and a wanted rate, both unsigned hertz values, and pulses `start`. The engine walks the legal output-divider window from the smallest value upward. For each output divider it walks the reference divider from 1 to 64 and derives one feedback multiplier per pair. It keeps the pair that gives the highest rate found so far and stops as soon as a pair hits the wanted rate exactly.

Every division, including the two that bound the output-divider window, goes through one shared restoring divider that produces one quotient bit per cycle. The control and the datapath are separate modules. A thin top joins them. The result registers hold the last answer until the next accepted start, so a consumer can read them at any time after `done`.

A wanted rate of zero is refused on the spot. Any search that finds no pair with a nonzero rate reports failure, and the rate and divider outputs then read zero.

Top module: `pll_search`

## Requirements
- R1: On success, `rateHz` equals `refHz*fMul/(2*rDiv*odDiv)` truncated, for the `rDiv`, `fMul` and `odDiv` returned, which are the plain divider values (not minus one).
- R2: Only output dividers from `120000000/targetHz + 1` up to `min(600000000/targetHz, 8)` are tried. When that window is empty the search fails.
- R3: Output dividers are visited in rising order, and for each one the reference divider runs from 1 to 64. A candidate replaces the best only when its rate is strictly higher, so of equal rates the first visited wins.
- R4: For each pair, `F = ((targetHz+1)*2*R*OD)/refHz`. A pair with `F == 0` is skipped, and `F` above 8192 is clamped to 8192.
- R5: A candidate that becomes the new best with a rate equal to `targetHz` ends the search at once with that candidate.
- R6: If no candidate gives a nonzero rate (including when `refHz` is 0), `noSolution` is 1 and `rateHz`, `rDiv`, `fMul` and `odDiv` are 0.
- R7: A `targetHz` of 0 sampled with an accepted start fails without searching: `done` is high in the second cycle after the start cycle.
- R8: A start seen while idle raises `busy` on the next cycle. `start` is ignored while `busy` is high. `done` is a one-cycle pulse that coincides with the first cycle of `busy` low.
- R9: `rateHz`, `rDiv`, `fMul`, `odDiv` and `noSolution` change only at the end of a search and otherwise hold, whatever the inputs do.
- R10: After reset, `busy`, `done`, `noSolution` and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search; sampled only while idle |
| refHz | input | 32 | Reference rate in hertz, captured at start |
| targetHz | input | 32 | Wanted rate in hertz, captured at start |
| busy | output | 1 | High while a search is running |
| done | output | 1 | One-cycle pulse when results are updated |
| noSolution | output | 1 | High when the last search found no usable pair |
| rateHz | output | 33 | Best achievable rate of the last search |
| rDiv | output | 7 | Chosen reference divider, 1 to 64 |
| fMul | output | 14 | Chosen feedback multiplier, 1 to 8192 |
| odDiv | output | 4 | Chosen output divider, 1 to 8 |

## Verification
The search is first run on directed pairs, each chosen to separate one rule:
- A first-pair exact hit shows the early exit and its short run time.
- A very high reference rate makes the first few feedback multipliers zero, so the result shows whether skipping works.
- A tiny reference rate forces the 8192 clamp.
- Wanted rates that leave the output-divider window empty from above and from below show the bounds.

Random wanted rates in the 400 to 600 MHz range and random reference rates, plus one wide-window case, are compared with a bench model of the same ordered search. Any change to the visiting order, the tie rule or the truncation shows up there as a different triple. A second start during a run and idle cycles with changed inputs show that inputs are captured only at an accepted start and that results hold.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

  // operand selection for the shared divider
  typedef enum logic [1:0] {
    SEL_LO,   // lower output-divider bound
    SEL_HI,   // upper output-divider bound
    SEL_F,    // feedback multiplier
    SEL_C     // candidate rate
  } divSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    loadIn;
    logic    divGo;
    divSel_e divSel;
    logic    capLo;
    logic    capHi;
    logic    capF;
    logic    capCur;
    logic    advance;
    logic    takeBest;
    logic    publish;
  } strobe_t;

  // status from datapath to control
  typedef struct packed {
    logic tgtInZero;
    logic odOk;
    logic fZero;
    logic better;
    logic exact;
    logic lastR;
    logic divFin;
  } flags_t;

endpackage

// File: rtl/pll_search_div.sv
module pll_search_div #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         fin,
  output logic [W-1:0] quotient
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  remQ, quoQ, dvsQ, remNext;
  logic [CW-1:0] cntQ;
  logic          finQ;
  logic [W:0]    shifted;
  logic [W+1:0]  trial;

  // one restoring step: shift in the next dividend bit, try a subtract
  always_comb begin
    shifted = {remQ, quoQ[W-1]};
    trial   = {1'b0, shifted} - {2'b00, dvsQ};
    remNext = trial[W+1] ? shifted[W-1:0] : trial[W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remQ <= '0;
      quoQ <= '0;
      dvsQ <= '0;
      cntQ <= '0;
      finQ <= 1'b0;
    end else begin
      finQ <= 1'b0;
      if (go) begin
        remQ <= '0;
        quoQ <= dividend;
        dvsQ <= divisor;
        cntQ <= CW'(W);
      end else if (cntQ != '0) begin
        remQ <= remNext;
        quoQ <= {quoQ[W-2:0], ~trial[W+1]};
        cntQ <= cntQ - CW'(1);
        finQ <= (cntQ == CW'(1));
      end
    end
  end

  assign fin      = finQ;
  assign quotient = quoQ;

  // R1: each division reports completion exactly once
  a_r1_fin_single: assert property (@(posedge clk) disable iff (!rstN)
    finQ |=> !finQ);
  // R1: a finished division leaves the divider idle
  a_r1_fin_idle: assert property (@(posedge clk) disable iff (!rstN)
    finQ |-> (cntQ == '0));

endmodule

// File: rtl/pll_search_ctrl.sv
module pll_search_ctrl
  import pll_search_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  flags_t  flg,
  output strobe_t stb,
  output logic    busy,
  output logic    done
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_LO_GO, ST_LO_WAIT, ST_HI_GO, ST_HI_WAIT, ST_OD_CHK,
    ST_F_GO, ST_F_WAIT, ST_F_CHK, ST_C_GO, ST_C_WAIT, ST_CMP, ST_FIN
  } state_e;

  state_e stateQ, nxt;
  logic   doneQ;

  always_comb begin
    stb = '0;
    nxt = stateQ;
    unique case (stateQ)
      ST_IDLE: if (start) begin
        stb.loadIn = 1'b1;
        nxt = flg.tgtInZero ? ST_FIN : ST_LO_GO;
      end
      ST_LO_GO: begin
        stb.divGo = 1'b1; stb.divSel = SEL_LO; nxt = ST_LO_WAIT;
      end
      ST_LO_WAIT: if (flg.divFin) begin
        stb.capLo = 1'b1; nxt = ST_HI_GO;
      end
      ST_HI_GO: begin
        stb.divGo = 1'b1; stb.divSel = SEL_HI; nxt = ST_HI_WAIT;
      end
      ST_HI_WAIT: if (flg.divFin) begin
        stb.capHi = 1'b1; nxt = ST_OD_CHK;
      end
      ST_OD_CHK: nxt = flg.odOk ? ST_F_GO : ST_FIN;
      ST_F_GO: begin
        stb.divGo = 1'b1; stb.divSel = SEL_F; nxt = ST_F_WAIT;
      end
      ST_F_WAIT: if (flg.divFin) begin
        stb.capF = 1'b1; nxt = ST_F_CHK;
      end
      ST_F_CHK: begin
        if (flg.fZero) begin
          stb.advance = 1'b1;
          nxt = flg.lastR ? ST_OD_CHK : ST_F_GO;
        end else begin
          nxt = ST_C_GO;
        end
      end
      ST_C_GO: begin
        stb.divGo = 1'b1; stb.divSel = SEL_C; nxt = ST_C_WAIT;
      end
      ST_C_WAIT: if (flg.divFin) begin
        stb.capCur = 1'b1; nxt = ST_CMP;
      end
      ST_CMP: begin
        stb.takeBest = flg.better;
        if (flg.better && flg.exact) begin
          nxt = ST_FIN;
        end else begin
          stb.advance = 1'b1;
          nxt = flg.lastR ? ST_OD_CHK : ST_F_GO;
        end
      end
      ST_FIN: begin
        stb.publish = 1'b1; nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= nxt;
      doneQ  <= (stateQ == ST_FIN);
    end
  end

  assign busy = (stateQ != ST_IDLE);
  assign done = doneQ;

  // R8: an idle start is accepted on the next edge
  a_r8_start_accept: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy);
  // R8: done lasts one cycle and only while idle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R7: zero target finishes two cycles after the start
  a_r7_zero_fast: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && flg.tgtInZero) |=> ##1 done);
  // R5: an exact new best ends the search
  a_r5_exact_stop: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_CMP && flg.better && flg.exact) |=> (stateQ == ST_FIN));

endmodule

// File: rtl/pll_search_dp.sv
module pll_search_dp
  import pll_search_pkg::*;
#(
  parameter int          FREQ_W   = 32,
  parameter int          DIV_W    = 48,
  parameter int          R_BITS   = 6,
  parameter int          F_BITS   = 13,
  parameter int          OD_BITS  = 3,
  parameter int unsigned OD_LO_HZ = 120000000,
  parameter int unsigned OD_HI_HZ = 600000000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [FREQ_W-1:0]   refHz,
  input  logic [FREQ_W-1:0]   targetHz,
  input  strobe_t             stb,
  output flags_t              flg,
  output logic [FREQ_W:0]     rateHz,
  output logic [R_BITS:0]     rDiv,
  output logic [F_BITS:0]     fMul,
  output logic [OD_BITS:0]    odDiv,
  output logic                noSolution
);
  localparam int R_MAX  = 1 << R_BITS;
  localparam int F_MAX  = 1 << F_BITS;
  localparam int OD_MAX = 1 << OD_BITS;
  localparam int RW     = R_BITS + 1;
  localparam int FW     = F_BITS + 1;
  localparam int OW     = OD_BITS + 1;
  localparam int RATE_W = FREQ_W + 1;

  logic [FREQ_W-1:0] refQ, tgtQ;
  logic [OW-1:0]     odLoQ, odHiQ, odQ, bestOd;
  logic [RW-1:0]     rQ, bestR;
  logic [FW-1:0]     fQ, bestF;
  logic [RATE_W-1:0] curQ, bestQ;

  logic [DIV_W-1:0] rod2W, dvd, dvs, q;
  logic             divFin;
  logic [OW-1:0]    odLoNext, odHiNext;
  logic [FW-1:0]    fNext;

  assign rod2W = (DIV_W'(rQ) * DIV_W'(odQ)) << 1;

  always_comb begin
    unique case (stb.divSel)
      SEL_LO: begin dvd = DIV_W'(OD_LO_HZ); dvs = DIV_W'(tgtQ); end
      SEL_HI: begin dvd = DIV_W'(OD_HI_HZ); dvs = DIV_W'(tgtQ); end
      SEL_F:  begin dvd = (DIV_W'(tgtQ) + DIV_W'(1)) * rod2W; dvs = DIV_W'(refQ); end
      default: begin dvd = DIV_W'(refQ) * DIV_W'(fQ); dvs = rod2W; end
    endcase
  end

  pll_search_div #(.W(DIV_W)) u_div (
    .clk(clk), .rstN(rstN), .go(stb.divGo),
    .dividend(dvd), .divisor(dvs), .fin(divFin), .quotient(q)
  );

  // saturate quotients into the narrow loop registers
  always_comb begin
    odLoNext = (q >= DIV_W'(OD_MAX)) ? OW'(OD_MAX + 1) : (q[OW-1:0] + OW'(1));
    odHiNext = (q >  DIV_W'(OD_MAX)) ? OW'(OD_MAX)     : q[OW-1:0];
    fNext    = (q >  DIV_W'(F_MAX))  ? FW'(F_MAX)      : q[FW-1:0];
  end

  always_comb begin
    flg.tgtInZero = (targetHz == '0);
    flg.odOk      = (odQ <= odHiQ);
    flg.fZero     = (fQ == '0);
    flg.better    = (curQ > bestQ);
    flg.exact     = (curQ == RATE_W'(tgtQ));
    flg.lastR     = (rQ == RW'(R_MAX));
    flg.divFin    = divFin;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refQ <= '0; tgtQ <= '0;
      odLoQ <= '0; odHiQ <= '0; odQ <= '0; rQ <= '0;
      fQ <= '0; curQ <= '0;
      bestQ <= '0; bestR <= '0; bestF <= '0; bestOd <= '0;
      rateHz <= '0; rDiv <= '0; fMul <= '0; odDiv <= '0; noSolution <= 1'b0;
    end else begin
      if (stb.loadIn) begin
        refQ <= refHz; tgtQ <= targetHz;
        bestQ <= '0; bestR <= '0; bestF <= '0; bestOd <= '0;
      end
      if (stb.capLo) odLoQ <= odLoNext;
      if (stb.capHi) begin
        odHiQ <= odHiNext;
        odQ   <= odLoQ;
        rQ    <= RW'(1);
      end
      if (stb.capF)   fQ   <= fNext;
      if (stb.capCur) curQ <= q[RATE_W-1:0];
      if (stb.advance) begin
        if (rQ == RW'(R_MAX)) begin
          rQ  <= RW'(1);
          odQ <= odQ + OW'(1);
        end else begin
          rQ <= rQ + RW'(1);
        end
      end
      if (stb.takeBest) begin
        bestQ <= curQ; bestR <= rQ; bestF <= fQ; bestOd <= odQ;
      end
      if (stb.publish) begin
        rateHz     <= bestQ;
        rDiv       <= bestR;
        fMul       <= bestF;
        odDiv      <= bestOd;
        noSolution <= (bestQ == '0);
      end
    end
  end

  // R2: a kept candidate lies inside the output-divider window
  a_r2_od_window: assert property (@(posedge clk) disable iff (!rstN)
    stb.takeBest |-> (odQ >= odLoQ && odQ <= odHiQ && odQ != '0 && odQ <= OW'(OD_MAX)));
  // R3: the best rate only ever rises
  a_r3_strict_gain: assert property (@(posedge clk) disable iff (!rstN)
    stb.takeBest |=> (bestQ > $past(bestQ)));
  // R4: a kept multiplier is nonzero and within the clamp
  a_r4_f_range: assert property (@(posedge clk) disable iff (!rstN)
    stb.takeBest |-> (fQ != '0 && fQ <= FW'(F_MAX)));
  // R3: reference divider stays within 1..64 during the walk
  a_r3_r_range: assert property (@(posedge clk) disable iff (!rstN)
    stb.capCur |-> (rQ != '0 && rQ <= RW'(R_MAX)));

endmodule

// File: rtl/pll_search.sv
module pll_search
  import pll_search_pkg::*;
#(
  parameter int FREQ_W  = 32,
  parameter int DIV_W   = 48,
  parameter int R_BITS  = 6,
  parameter int F_BITS  = 13,
  parameter int OD_BITS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [FREQ_W-1:0] refHz,
  input  logic [FREQ_W-1:0] targetHz,
  output logic              busy,
  output logic              done,
  output logic              noSolution,
  output logic [FREQ_W:0]   rateHz,
  output logic [R_BITS:0]   rDiv,
  output logic [F_BITS:0]   fMul,
  output logic [OD_BITS:0]  odDiv
);
  strobe_t stb;
  flags_t  flg;

  pll_search_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .flg(flg),
    .stb(stb), .busy(busy), .done(done)
  );

  pll_search_dp #(
    .FREQ_W(FREQ_W), .DIV_W(DIV_W), .R_BITS(R_BITS),
    .F_BITS(F_BITS), .OD_BITS(OD_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .refHz(refHz), .targetHz(targetHz),
    .stb(stb), .flg(flg), .rateHz(rateHz), .rDiv(rDiv),
    .fMul(fMul), .odDiv(odDiv), .noSolution(noSolution)
  );

  // R9: results hold while idle and no start arrives
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(rateHz) && $stable(rDiv) && $stable(fMul)
                           && $stable(odDiv) && $stable(noSolution)));
  // R6: a reported failure carries zero results
  a_r6_fail_zero: assert property (@(posedge clk) disable iff (!rstN)
    (done && noSolution) |-> (rateHz == '0 && rDiv == '0 && fMul == '0 && odDiv == '0));

endmodule

// File: tb/sim_pll_search.sv
module sim_pll_search;
  logic        clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [31:0] refHz = '0, targetHz = '0;
  logic        busy, done, noSolution;
  logic [32:0] rateHz;
  logic [6:0]  rDiv;
  logic [13:0] fMul;
  logic [3:0]  odDiv;

  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pll_search u0 (
    .clk(clk), .rstN(rstN), .start(start), .refHz(refHz), .targetHz(targetHz),
    .busy(busy), .done(done), .noSolution(noSolution), .rateHz(rateHz),
    .rDiv(rDiv), .fMul(fMul), .odDiv(odDiv)
  );

  task automatic check(input string tag, input bit ok, input string what,
                       input longint unsigned act, input longint unsigned exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // ordered search model written from the requirements
  function automatic void model(input longint unsigned refv, input longint unsigned tgtv,
                                output longint unsigned rate, output longint unsigned rb,
                                output longint unsigned fb, output longint unsigned ob,
                                output bit fail);
    longint unsigned odLo, odHi, rod2, f, cur;
    rate = 0; rb = 0; fb = 0; ob = 0; fail = 1'b1;
    if (tgtv == 0 || refv == 0) return;
    odLo = 120000000 / tgtv + 1;
    odHi = 600000000 / tgtv;
    if (odHi > 8) odHi = 8;
    for (longint unsigned od = odLo; od <= odHi; od++) begin
      for (longint unsigned r = 1; r <= 64; r++) begin
        rod2 = 2 * r * od;
        f = ((tgtv + 1) * rod2) / refv;
        if (f < 1) continue;
        if (f > 8192) f = 8192;
        cur = (refv * f) / rod2;
        if (cur > rate) begin
          rate = cur; rb = r; fb = f; ob = od; fail = 1'b0;
          if (cur == tgtv) return;
        end
      end
    end
  endfunction

  task automatic checkResult(input string tag, input longint unsigned refv,
                             input longint unsigned tgtv);
    longint unsigned er, eR, eF, eO;
    bit ef;
    model(refv, tgtv, er, eR, eF, eO, ef);
    check(tag, rateHz == er, "rateHz", rateHz, er);
    check(tag, rDiv == eR, "rDiv", rDiv, eR);
    check(tag, fMul == eF, "fMul", fMul, eF);
    check(tag, odDiv == eO, "odDiv", odDiv, eO);
    check(tag, noSolution == ef, "noSolution", noSolution, ef);
  endtask

  // start a search, wait for done, check handshake (R8) and results
  task automatic runOne(input string tag, input longint unsigned refv,
                        input longint unsigned tgtv, output int cycles);
    @(negedge clk);
    refHz = refv[31:0]; targetHz = tgtv[31:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({tag, " R8 busy"}, busy == 1'b1, "busy after start", busy, 1);
    cycles = 0;
    while (!done) begin
      @(negedge clk);
      cycles++;
    end
    check({tag, " R8 idle at done"}, busy == 1'b0, "busy", busy, 0);
    checkResult(tag, refv, tgtv);
    @(negedge clk);
    check({tag, " R8 pulse"}, done == 1'b0, "done width", done, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    int cyc;
    int unsigned seedDummy;
    longint unsigned rv, tv;

    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", busy == 0 && done == 0, "busy|done", {busy, done}, 0);
    check("R10", rateHz == 0 && noSolution == 0, "rate|fail", rateHz, 0);
    check("R10", rDiv == 0 && fMul == 0 && odDiv == 0, "dividers", fMul, 0);
    rstN = 1'b1;

    // R5: 24 MHz -> 96 MHz exact at OD=2, R=1, F=16 on the first pair
    runOne("R5 exact", 24000000, 96000000, cyc);
    check("R5 triple", rDiv == 1 && fMul == 16 && odDiv == 2, "fMul", fMul, 16);
    check("R5 early", cyc < 400, "cycles", cyc, 400);

    // R4: F is zero for R<5, R=5 gives F=1 and an exact 400 MHz
    runOne("R4 skip", 64'd4000000000, 400000000, cyc);
    check("R4 skip triple", rDiv == 5 && fMul == 1 && odDiv == 1, "rDiv", rDiv, 5);

    // R4: clamp to 8192, best at R=1, OD=1, rate 1000*8192/2
    runOne("R4 clamp", 1000, 500000000, cyc);
    check("R4 clamp F", fMul == 8192 && rateHz == 4096000, "rateHz", rateHz, 4096000);

    // R7: zero target fails at once
    runOne("R7 zero", 24000000, 0, cyc);
    check("R7 fast", cyc == 1, "cycles", cyc, 1);

    // R2: window empty from above (upper bound 0) and below (lower bound 13)
    runOne("R2 high", 24000000, 700000000, cyc);
    runOne("R2 low", 24000000, 10000000, cyc);

    // R6: zero reference gives no usable rate
    runOne("R6 zero ref", 0, 500000000, cyc);
    check("R6 flag", noSolution == 1 && rateHz == 0, "noSolution", noSolution, 1);

    // R3: wide window, order and tie rule against the model
    runOne("R3 wide", 27000000, 77777777, cyc);

    // R8: a second start during a run is ignored
    @(negedge clk);
    refHz = 24000000; targetHz = 96000000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    refHz = 1000; targetHz = 500000000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    checkResult("R8 ignore start", 24000000, 96000000);

    // R1: random pairs against the model
    seedDummy = $urandom(32'd20240611);
    for (int i = 0; i < 6; i++) begin
      rv = 64'(1000000 + ($urandom % 100000000));
      tv = 64'(400000000 + ($urandom % 200000001));
      runOne("R1 random", rv, tv, cyc);
    end

    // R9: results hold over idle cycles with changed inputs
    rv = rateHz; tv = fMul;
    refHz = 5; targetHz = 7;
    repeat (50) @(negedge clk);
    check("R9 hold rate", rateHz == rv, "rateHz", rateHz, rv);
    check("R9 hold F", fMul == tv, "fMul", fMul, tv);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule